// File: doc/BRIEF.md
# Fibre-Channel Receive Link Synchronizer

This block sits behind an 8b/10b decoder on one receive lane and decides whether the lane is word-synchronized. It takes one decoded character per valid strobe, together with a K-character flag, the eight data bits, a code-violation flag (disparity error) and a misaligned-comma flag. It groups the characters into four-character words, and a word whose first character is the comma K28.5 counts as an idle ordered set.

Out of sync, the block looks for three idle ordered sets in a row with no error inside or between them. Each comma found off a word boundary realigns the word framing. In sync, it keeps a count of bad words and drops sync when the count reaches four. Each pair of consecutive good words cancels one earlier bad word. A `dbg_state` output exposes the state, so that every transition can be seen at the ports.

Top module: `fc_link_sync`

## Requirements
- R1: While `rst` is high, and in the cycle after it, `word_sync` is 0 and `dbg_state` is 0.
- R2: A comma is a character with `chr_k`=1 and `chr_data`=8'hBC. An idle ordered set is a four-character word whose first character is a comma. The sequence BC(K), 95, B5, B5, sent three times with no error, sets `word_sync` to 1 at the clock edge that takes the twelfth character. After the first and second idle sets `dbg_state` reads 1 and then 2.
- R3: Out of sync, a word that contains a character with `chr_cv` or `chr_misalign` set returns `dbg_state` to 0 at the end of that word.
- R4: Out of sync, an error-free word that is not an idle ordered set returns `dbg_state` to 0.
- R5: Out of sync, a comma at a character position other than 0 clears the idle count on that character and starts a new word. The comma is character 0 of the new word.
- R6: A cycle with `chr_vld`=0 changes no state, whatever the other inputs carry.
- R7: In sync, each bad word raises the violation count by one (`dbg_state` 4→5→6→7). A bad word at count 3 drops `word_sync` to 0, and `dbg_state` goes to 0.
- R8: In sync, with a nonzero violation count, two consecutive good words lower the count by one. A bad word between them restarts the pairing.
- R9: In sync, a comma at character position 1, 2 or 3 makes that word bad.
- R10: With `en` low, the next clock edge forces `word_sync` to 0 and `dbg_state` to 0.
- R11: `dbg_state` reads {0, idle count} out of sync and {1, violation count} in sync. Its top bit always equals `word_sync`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Enable; low holds the loss-of-sync state |
| chr_vld | input | 1 | Character strobe |
| chr_k | input | 1 | Character is a K code |
| chr_data | input | 8 | Decoded character bits |
| chr_cv | input | 1 | Disparity or code violation on this character |
| chr_misalign | input | 1 | Comma seen misaligned by the aligner |
| word_sync | output | 1 | Link word synchronization achieved |
| dbg_state | output | DW (3) | State code, see R11 |

## Verification
A wrong count or a wrong word phase shows on `dbg_state` at the end of the next word, four valid characters later. A slip in phase also turns the next idle set into a bad or non-idle word, which moves `dbg_state` away from the expected value at once. An error in the forgiveness pairing only appears after a later bad word: `word_sync` then falls one word too early or too late. The stimulus therefore runs long chains of bad and good words in sync and checks the code after every word.

// File: rtl/fc_link_sync.sv
module fc_link_sync #(
  parameter int ACQ_WORDS = 3,
  parameter int LOSS_WORDS = 4,
  parameter int FORGIVE_WORDS = 2,
  parameter logic [7:0] COMMA_CODE = 8'hBC,
  localparam int AW = $clog2(ACQ_WORDS),
  localparam int VW = $clog2(LOSS_WORDS),
  localparam int GW = $clog2(FORGIVE_WORDS + 1),
  localparam int DW = 1 + ((AW > VW) ? AW : VW)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          chr_vld,
  input  logic          chr_k,
  input  logic [7:0]    chr_data,
  input  logic          chr_cv,
  input  logic          chr_misalign,
  output logic          word_sync,
  output logic [DW-1:0] dbg_state
);

  logic [1:0]    phase;
  logic          wos, werr;
  logic [AW-1:0] cnt;
  logic [VW-1:0] viol;
  logic [GW-1:0] good;

  wire comma     = chr_k && (chr_data == COMMA_CODE);
  wire last      = (phase == 2'd3);
  wire misplaced = comma && (phase != 2'd0);
  wire realign   = !word_sync && misplaced;
  wire bad_now   = chr_cv | chr_misalign | (word_sync & misplaced);
  wire w_bad     = werr | bad_now;

  assign dbg_state = word_sync ? {1'b1, (DW-1)'(viol)} : {1'b0, (DW-1)'(cnt)};

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      phase     <= '0;
      wos       <= 1'b0;
      werr      <= 1'b0;
      cnt       <= '0;
      viol      <= '0;
      good      <= '0;
      word_sync <= 1'b0;
    end else if (chr_vld) begin
      if (realign) begin
        phase <= 2'd1;
        wos   <= 1'b1;
        werr  <= chr_cv | chr_misalign;
        cnt   <= '0;
      end else begin
        phase <= phase + 2'd1;
        if (phase == 2'd0) begin
          wos  <= comma;
          werr <= bad_now;
        end else begin
          werr <= werr | bad_now;
        end
        if (last) begin
          if (!word_sync) begin
            if (w_bad || !wos) begin
              cnt <= '0;
            end else if (cnt == AW'(ACQ_WORDS - 1)) begin
              word_sync <= 1'b1;
              cnt       <= '0;
              viol      <= '0;
              good      <= '0;
            end else begin
              cnt <= cnt + AW'(1);
            end
          end else if (w_bad) begin
            good <= '0;
            if (viol == VW'(LOSS_WORDS - 1)) begin
              word_sync <= 1'b0;
              viol      <= '0;
            end else begin
              viol <= viol + VW'(1);
            end
          end else if (viol != '0) begin
            if (good == GW'(FORGIVE_WORDS - 1)) begin
              good <= '0;
              viol <= viol - VW'(1);
            end else begin
              good <= good + GW'(1);
            end
          end
        end
      end
    end
  end

endmodule

// File: rtl/fc_link_sync_chk.sv
module fc_link_sync_chk #(
  parameter int ACQ_WORDS = 3,
  parameter int LOSS_WORDS = 4,
  localparam int AW = $clog2(ACQ_WORDS),
  localparam int VW = $clog2(LOSS_WORDS),
  localparam int DW = 1 + ((AW > VW) ? AW : VW)
) (
  input logic          clk,
  input logic          rst,
  input logic          en,
  input logic          chr_vld,
  input logic          word_sync,
  input logic [DW-1:0] dbg_state
);

  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (dbg_state == '0 && !word_sync));

  a_r10_enable_low: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!word_sync && dbg_state == '0));

  a_r6_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (en && !chr_vld) |=> $stable(dbg_state));

  a_r2_rise_after_idles: assert property (@(posedge clk) disable iff (rst)
    $rose(word_sync) |-> ($past(dbg_state) == DW'(ACQ_WORDS - 1) && $past(chr_vld)));

  a_r7_loss_at_top: assert property (@(posedge clk) disable iff (rst)
    ($fell(word_sync) && $past(en) && !$past(rst)) |->
      ($past(dbg_state) == DW'((1 << (DW-1)) | (LOSS_WORDS - 1))));

endmodule

bind fc_link_sync fc_link_sync_chk #(.ACQ_WORDS(ACQ_WORDS), .LOSS_WORDS(LOSS_WORDS)) u_chk (
  .clk(clk), .rst(rst), .en(en), .chr_vld(chr_vld),
  .word_sync(word_sync), .dbg_state(dbg_state)
);

// File: tb/sim_fc_link_sync.sv
module sim_fc_link_sync;
  localparam int CLK_PERIOD = 10;
  localparam int IDLE = 0, DATA = 1, CVW = 2, MISW = 3, MIDC = 4;
  localparam int NV = 26;
  localparam logic [5:0] VEC [NV] = '{
    {3'(IDLE), 3'd1}, {3'(IDLE), 3'd2}, {3'(CVW), 3'd0}, {3'(IDLE), 3'd1},
    {3'(DATA), 3'd0}, {3'(IDLE), 3'd1}, {3'(IDLE), 3'd2}, {3'(IDLE), 3'd4},
    {3'(CVW), 3'd5},  {3'(DATA), 3'd5}, {3'(DATA), 3'd4}, {3'(CVW), 3'd5},
    {3'(DATA), 3'd5}, {3'(CVW), 3'd6},  {3'(DATA), 3'd6}, {3'(MISW), 3'd7},
    {3'(IDLE), 3'd7}, {3'(IDLE), 3'd6}, {3'(CVW), 3'd7},  {3'(CVW), 3'd0},
    {3'(IDLE), 3'd1}, {3'(IDLE), 3'd2}, {3'(IDLE), 3'd4}, {3'(MIDC), 3'd5},
    {3'(DATA), 3'd5}, {3'(DATA), 3'd4}
  };

  logic clk = 0, rst = 1, en = 1, chr_vld = 0, chr_k = 0, chr_cv = 0, chr_misalign = 0;
  logic [7:0] chr_data = 0;
  logic word_sync;
  logic [2:0] dbg_state;
  int checks = 0, errors = 0;

  fc_link_sync u0 (.clk(clk), .rst(rst), .en(en), .chr_vld(chr_vld), .chr_k(chr_k),
    .chr_data(chr_data), .chr_cv(chr_cv), .chr_misalign(chr_misalign),
    .word_sync(word_sync), .dbg_state(dbg_state));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(string req, logic [2:0] exp);
    checks++;
    if (dbg_state !== exp || word_sync !== exp[2]) begin
      errors++;
      $display("FAIL %s: dbg_state=%0d word_sync=%0b expected dbg_state=%0d word_sync=%0b",
               req, dbg_state, word_sync, exp, exp[2]);
    end
  endtask

  task automatic send_char(logic k, logic [7:0] d, logic cv, logic mis);
    @(negedge clk);
    chr_vld = 1; chr_k = k; chr_data = d; chr_cv = cv; chr_misalign = mis;
  endtask

  task automatic send_gap();
    @(negedge clk);
    chr_vld = 0; chr_k = 1; chr_data = 8'hBC; chr_cv = 1; chr_misalign = 1;
  endtask

  task automatic settle();
    @(posedge clk); #1;
  endtask

  task automatic send_word(int kind, bit gaps);
    for (int i = 0; i < 4; i++) begin
      logic k = 0, cv = 0, mis = 0;
      logic [7:0] d = 8'hB5;
      if ((kind == IDLE && i == 0) || (kind == MIDC && i == 2)) begin k = 1; d = 8'hBC; end
      if (kind == IDLE && i == 1) d = 8'h95;
      if (kind == CVW && i == 2) cv = 1;
      if (kind == MISW && i == 1) mis = 1;
      send_char(k, d, cv, mis);
      if (gaps && i == 1) send_gap();
    end
    settle();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 check("R1 reset", 3'd0);
    @(negedge clk) rst = 0;
    // R2 R3 R4 R6 R7 R8 R9 R11: vector walk, gaps with garbage on odd entries
    for (int v = 0; v < NV; v++) begin
      send_word(int'(VEC[v][5:3]), v[0]);
      check($sformatf("R2/R3/R4/R6/R7/R8/R9/R11 vector %0d", v), VEC[v][2:0]);
    end
    // R10: enable low drops sync
    @(negedge clk) en = 0; chr_vld = 0;
    settle();
    check("R10 enable low", 3'd0);
    @(negedge clk) en = 1;
    // R5: misplaced comma out of sync realigns and clears the count
    send_word(IDLE, 0);
    check("R5 first idle", 3'd1);
    send_char(0, 8'hB5, 0, 0);
    send_char(1, 8'hBC, 0, 0);
    settle();
    check("R5 count cleared on misplaced comma", 3'd0);
    send_char(0, 8'h95, 0, 0);
    send_char(0, 8'hB5, 0, 0);
    send_char(0, 8'hB5, 0, 0);
    settle();
    check("R5 realigned word counts as idle", 3'd1);
    send_word(IDLE, 0);
    send_word(IDLE, 1);
    check("R5 sync after realign", 3'd4);
    // R1: reset from sync
    @(negedge clk) rst = 1; chr_vld = 0;
    settle();
    check("R1 reset from sync", 3'd0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule